// File: doc/BRIEF.md
# Serial NAND Command-Queue Sequencer

This block is a programmed-I/O serial flash master. Software does not build a frame in a transfer register. It stages typed micro-operations and pushes them into a small operation queue. Each micro-operation carries an operation code and a byte count. The sequencer takes the operations one at a time, in the order they were queued. Each operation does one of three things: it moves chip select, it clocks bytes out of the transmit byte queue, or it clocks bytes into the receive byte queue. The operation code picks both the direction and how many data lines carry the bits (one, two or four).

A typical flash command is built from a short run of operations. First chip select goes low. Then the command byte, the address bytes and the dummy bytes (sent as 0xFF) go out as transmit operations. Next comes a transmit or receive operation for the data phase. Last, chip select is raised. A transfer longer than one operation can carry is split across several operations. The host polls the full and empty flags of all three queues.

The serial interface works in mode 0. SCK idles low, outgoing data changes on the falling edge, and incoming data is sampled on the rising edge. Each bit group takes two core clocks.

Top module: `snand_seq`

## Requirements
- R1: After reset, chip select is high, SCK is low, no data line is driven, and the operation, transmit and receive queues are all empty.
- R2: A write to the staging register does not queue anything by itself. The staged word enters the operation queue only when the push strobe is pulsed.
- R3: An operation word holds the byte count in bits 8:0 and the operation code in bits 13:9. Operations run strictly in the order they were queued.
- R4: Code 0x01 drives chip select low and code 0x00 drives it high, with no SCK pulses. Both are issued with a count of 1.
- R5: Codes 0x08, 0x09 and 0x0A transmit on one line (line 0), two lines (lines 1:0) or four lines (lines 3:0). Each byte goes out most significant group first. A quad byte is high nibble then low nibble. Output data never changes at a rising SCK edge, and SCK high lasts one core clock.
- R6: Codes 0x0C, 0x0E and 0x0F receive on one line (line 1), two lines (lines 1:0) or four lines (lines 3:0), with all outputs released. Each completed byte, assembled most significant group first, is written to the receive queue.
- R7: The receive queue always presents its oldest byte on the read-data port, and a pop strobe removes that byte. A pop on an empty queue has no effect.
- R8: If a transmit operation needs a byte while the transmit queue is empty, SCK stays low until a byte is written. The transfer then continues with no byte lost.
- R9: If a receive operation needs room while the receive queue is full, SCK stays low until the host pops a byte. No data is lost.
- R10: An operation with an unrecognised code, or a data operation with a count of 0, is consumed with no SCK pulse and no change to chip select.
- R11: A data operation clocks exactly its 9-bit count of bytes, up to 511, including counts above 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the staging register |
| cmd_wdata | input | 14 | Operation word: code in 13:9, count in 8:0 |
| cmd_go | input | 1 | Push the staged word into the operation queue |
| cmd_full | output | 1 | Operation queue is full |
| cmd_empty | output | 1 | Operation queue is empty |
| tx_wr | input | 1 | Push one byte into the transmit queue |
| tx_wdata | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue is full |
| tx_empty | output | 1 | Transmit queue is empty |
| rx_pop | input | 1 | Remove the head byte of the receive queue |
| rx_rdata | output | 8 | Head byte of the receive queue |
| rx_full | output | 1 | Receive queue is full |
| rx_empty | output | 1 | Receive queue is empty |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_dout | output | 4 | Data line outputs |
| spi_doe | output | 4 | Per-line output enables |
| spi_din | input | 4 | Data line inputs |

## Verification
The two events that can land in the same cycle are a host pop and an engine write on the receive queue. One receive test lets the queue fill completely. The engine then stalls, and the host drains the queue. While the host drains, every pop frees a slot, and the engine writes the next byte into that slot at or near the same edge. The check is twofold. The SCK edge count must stay frozen while the queue is full. Then every byte popped must match, in order, the byte the bench slave shifted in, with none lost or repeated. The same kind of overlap on the transmit side happens in every transmit test: the bench writes bytes while the engine takes them, and the bench compares the bytes it captures on the lines against the bytes it queued.

// File: rtl/snand_seq_pkg.sv
// Shared types for the serial NAND command-queue sequencer.
// Assumes an operation word of 14 bits: code in 13:9, byte count in 8:0.
package snand_seq_pkg;
    localparam int OP_W   = 5;
    localparam int LEN_W  = 9;
    localparam int WORD_W = OP_W + LEN_W;

    localparam logic [OP_W-1:0] OP_CS_HIGH = 5'h00;
    localparam logic [OP_W-1:0] OP_CS_LOW  = 5'h01;
    localparam logic [OP_W-1:0] OP_TX_X1   = 5'h08;
    localparam logic [OP_W-1:0] OP_TX_X2   = 5'h09;
    localparam logic [OP_W-1:0] OP_TX_X4   = 5'h0A;
    localparam logic [OP_W-1:0] OP_RX_X1   = 5'h0C;
    localparam logic [OP_W-1:0] OP_RX_X2   = 5'h0E;
    localparam logic [OP_W-1:0] OP_RX_X4   = 5'h0F;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [LEN_W-1:0] len;
    } op_word_t;

    typedef enum logic [1:0] {LANE_X1, LANE_X2, LANE_X4} lane_e;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_LOW, ST_HIGH} eng_st_e;
endpackage

// File: rtl/snand_fifo.sv
// Synchronous show-ahead FIFO. The head entry is always visible on rd_data.
// Assumes DEPTH is a power of two. A write while full or a read while empty is ignored.
module snand_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wptr, rptr;
    logic         do_wr, do_rd;

    assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    assign empty   = (wptr == rptr);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rptr[AW-1:0]];

    // Store an accepted entry at the write slot.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr[AW-1:0]] <= wr_data;
    end

    // Advance the pointers for accepted writes and reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
        end
    end
endmodule

// File: rtl/snand_shift_engine.sv
// Takes operation words one at a time and carries them out: moves chip select,
// or shifts bytes out of or into the byte queues on 1, 2 or 4 lines in SPI mode 0.
// Assumes show-ahead queues. Stalls with SCK low when no byte or no room is available.
module snand_shift_engine
    import snand_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  op_word_t   op_word,
    output logic       op_take,
    input  logic       tx_valid,
    input  logic [7:0] tx_byte,
    output logic       tx_take,
    input  logic       rx_room_n,
    output logic       rx_put,
    output logic [7:0] rx_byte,
    output logic       spi_cs_n,
    output logic       spi_sck,
    output logic [3:0] spi_dout,
    output logic [3:0] spi_doe,
    input  logic [3:0] spi_din
);
    eng_st_e          st;
    lane_e            lane;
    logic             is_rx;
    logic [LEN_W-1:0] left;
    logic [2:0]       grp;
    logic [7:0]       shreg;
    logic [7:0]       cap_next;
    logic [7:0]       shift_next;
    logic [2:0]       grp_last;
    logic [3:0]       lane_mask;
    logic [3:0]       lane_bits;
    logic             can_go;

    // Per-lane shift, capture, group count and enable mask.
    always_comb begin
        unique case (lane)
            LANE_X2: begin
                cap_next   = {shreg[5:0], spi_din[1:0]};
                shift_next = {shreg[5:0], 2'b00};
                grp_last   = 3'd3;
                lane_mask  = 4'b0011;
                lane_bits  = {2'b00, shreg[7:6]};
            end
            LANE_X4: begin
                cap_next   = {shreg[3:0], spi_din};
                shift_next = {shreg[3:0], 4'b0000};
                grp_last   = 3'd1;
                lane_mask  = 4'b1111;
                lane_bits  = shreg[7:4];
            end
            default: begin
                cap_next   = {shreg[6:0], spi_din[1]};
                shift_next = {shreg[6:0], 1'b0};
                grp_last   = 3'd7;
                lane_mask  = 4'b0001;
                lane_bits  = {3'b000, shreg[7]};
            end
        endcase
    end

    // Handshakes with the three queues and the pad drive.
    always_comb begin
        can_go   = is_rx ? !rx_room_n : tx_valid;
        op_take  = (st == ST_IDLE) && op_valid;
        tx_take  = (st == ST_FETCH) && !is_rx && tx_valid;
        rx_put   = (st == ST_HIGH) && is_rx && (grp == 3'd0);
        rx_byte  = shreg;
        spi_doe  = ((st != ST_IDLE) && !is_rx) ? lane_mask : 4'b0000;
        spi_dout = lane_bits & spi_doe;
    end

    // Operation decode and per-group state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            lane     <= LANE_X1;
            is_rx    <= 1'b0;
            left     <= '0;
            grp      <= '0;
            shreg    <= '0;
            spi_cs_n <= 1'b1;
            spi_sck  <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (op_valid) begin
                    case (op_word.op)
                        OP_CS_HIGH: spi_cs_n <= 1'b1;
                        OP_CS_LOW:  spi_cs_n <= 1'b0;
                        OP_TX_X1, OP_TX_X2, OP_TX_X4,
                        OP_RX_X1, OP_RX_X2, OP_RX_X4: begin
                            is_rx <= op_word.op[2];
                            lane  <= (op_word.op == OP_TX_X2 || op_word.op == OP_RX_X2) ? LANE_X2 :
                                     (op_word.op == OP_TX_X4 || op_word.op == OP_RX_X4) ? LANE_X4 :
                                     LANE_X1;
                            left  <= op_word.len;
                            if (op_word.len != '0) st <= ST_FETCH;
                        end
                        default: ;
                    endcase
                end
                ST_FETCH: if (can_go) begin
                    shreg <= is_rx ? 8'h00 : tx_byte;
                    grp   <= grp_last;
                    st    <= ST_LOW;
                end
                ST_LOW: begin
                    spi_sck <= 1'b1;
                    if (is_rx) shreg <= cap_next;
                    st <= ST_HIGH;
                end
                ST_HIGH: begin
                    spi_sck <= 1'b0;
                    if (!is_rx) shreg <= shift_next;
                    if (grp == 3'd0) begin
                        left <= left - 1'b1;
                        st   <= (left == 9'd1) ? ST_IDLE : ST_FETCH;
                    end else begin
                        grp <= grp - 1'b1;
                        st  <= ST_LOW;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/snand_seq.sv
// Top of the serial NAND command-queue sequencer. Holds the staging register,
// the operation queue, the transmit and receive byte queues, and the shift engine.
// Assumes the host pulses cmd_go only after the wanted word is staged.
module snand_seq
    import snand_seq_pkg::*;
#(
    parameter int OPQ_DEPTH  = 4,
    parameter int DATA_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_wdata,
    input  logic              cmd_go,
    output logic              cmd_full,
    output logic              cmd_empty,
    input  logic              tx_wr,
    input  logic [7:0]        tx_wdata,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              rx_pop,
    output logic [7:0]        rx_rdata,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic [3:0]        spi_dout,
    output logic [3:0]        spi_doe,
    input  logic [3:0]        spi_din
);
    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] opq_head;
    logic              eng_op_take;
    logic              eng_tx_take;
    logic              eng_rx_put;
    logic [7:0]        eng_rx_byte;
    logic [7:0]        txq_head;

    // Staging register: holds the word until the push strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q <= '0;
        else if (cmd_wr) stage_q <= cmd_wdata;
    end

    snand_fifo #(.W(WORD_W), .DEPTH(OPQ_DEPTH)) u_opq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cmd_go), .wr_data(stage_q),
        .rd_en(eng_op_take), .rd_data(opq_head),
        .full(cmd_full), .empty(cmd_empty)
    );

    snand_fifo #(.W(8), .DEPTH(DATA_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tx_wr), .wr_data(tx_wdata),
        .rd_en(eng_tx_take), .rd_data(txq_head),
        .full(tx_full), .empty(tx_empty)
    );

    snand_fifo #(.W(8), .DEPTH(DATA_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(eng_rx_put), .wr_data(eng_rx_byte),
        .rd_en(rx_pop), .rd_data(rx_rdata),
        .full(rx_full), .empty(rx_empty)
    );

    snand_shift_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .op_valid(!cmd_empty), .op_word(op_word_t'(opq_head)), .op_take(eng_op_take),
        .tx_valid(!tx_empty), .tx_byte(txq_head), .tx_take(eng_tx_take),
        .rx_room_n(rx_full), .rx_put(eng_rx_put), .rx_byte(eng_rx_byte),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_dout(spi_dout), .spi_doe(spi_doe), .spi_din(spi_din)
    );
endmodule

// File: rtl/snand_seq_chk.sv
// Property checker for snand_seq, attached by the bind at the end of this file.
// Assumes the synchronous active-low reset of the top.
module snand_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_go,
    input logic       cmd_full,
    input logic       cmd_empty,
    input logic       rx_empty,
    input logic       rx_put,
    input logic       spi_sck,
    input logic [3:0] spi_dout,
    input logic [3:0] spi_doe
);
    // Nothing enters the operation queue without the push strobe.
    assert_no_silent_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_empty && !cmd_go) |=> cmd_empty);

    // Operation queue flags never claim full and empty together.
    assert_opq_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_full && cmd_empty));

    // SCK high lasts exactly one core clock.
    assert_sck_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |=> !spi_sck);

    // Output data does not move at a rising SCK edge.
    assert_dout_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> $stable(spi_dout));

    // Drive enables are one of the legal lane sets.
    assert_lane_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_doe == 4'b0000) || (spi_doe == 4'b0001) ||
        (spi_doe == 4'b0011) || (spi_doe == 4'b1111));

    // The receive queue gets no entry without an engine write.
    assert_rxq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && !rx_put) |=> rx_empty);
endmodule

bind snand_seq snand_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .cmd_go(cmd_go), .cmd_full(cmd_full), .cmd_empty(cmd_empty),
    .rx_empty(rx_empty), .rx_put(eng_rx_put),
    .spi_sck(spi_sck), .spi_dout(spi_dout), .spi_doe(spi_doe)
);

// File: tb/test_snand_seq.sv
module test_snand_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0, cmd_go = 1'b0;
    logic [13:0] cmd_wdata = '0;
    logic        cmd_full, cmd_empty;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_wdata = '0;
    logic        tx_full, tx_empty;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_rdata;
    logic        rx_full, rx_empty;
    logic        spi_cs_n, spi_sck;
    logic [3:0]  spi_dout, spi_doe, spi_din;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    snand_seq i_snand_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_go(cmd_go),
        .cmd_full(cmd_full), .cmd_empty(cmd_empty),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_full(rx_full), .rx_empty(rx_empty),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_dout(spi_dout),
        .spi_doe(spi_doe), .spi_din(spi_din)
    );

    // Line monitor: counts SCK edges, assembles transmitted bytes.
    logic [7:0] exp_b [512];
    logic [7:0] cap_b [512];
    int cap_n = 0, cap_bits = 0, cap_sh = 0, sck_rises = 0, sck_cs_high = 0;
    always @(posedge spi_sck) begin
        int w;
        sck_rises++;
        if (spi_cs_n) sck_cs_high++;
        if (spi_doe != 4'b0000) begin
            w = (spi_doe == 4'b0001) ? 1 : (spi_doe == 4'b0011) ? 2 : 4;
            cap_sh = (cap_sh << w) | (int'(spi_dout) & ((1 << w) - 1));
            cap_bits += w;
            if (cap_bits >= 8) begin
                if (cap_n < 512) cap_b[cap_n] = cap_sh[7:0];
                cap_n++;
                cap_bits = 0;
                cap_sh = 0;
            end
        end
    end

    // Slave model: presents the next bit group, advances on each falling SCK.
    logic [7:0] pat_b [512];
    bit rx_active = 0;
    int rx_w = 1, g = 0;
    always @(negedge spi_sck) if (rx_active) g++;
    always_comb begin
        int bi, k, v;
        bi = g / (8 / rx_w);
        k  = g % (8 / rx_w);
        v  = (bi < 512) ? ((int'(pat_b[bi]) >> (8 - rx_w * (k + 1))) & ((1 << rx_w) - 1)) : 0;
        if (!rx_active)     spi_din = 4'h0;
        else if (rx_w == 1) spi_din = {2'b00, v[0], 1'b0};
        else                spi_din = v[3:0];
    end

    function automatic logic [13:0] word(input logic [4:0] op, input int len);
        return {op, len[8:0]};
    endfunction

    function automatic logic [4:0] tx_code(input int w);
        return (w == 1) ? 5'h08 : (w == 2) ? 5'h09 : 5'h0A;
    endfunction

    function automatic logic [4:0] rx_code(input int w);
        return (w == 1) ? 5'h0C : (w == 2) ? 5'h0E : 5'h0F;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_cmd(input logic [4:0] op, input int len);
        while (cmd_full) @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = word(op, len);
        @(negedge clk);
        cmd_wr = 1'b0; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    task automatic wait_frame_end();
        int t = 0;
        while (!(spi_cs_n && cmd_empty) && t < 30000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
    endtask

    task automatic run_tx(input int w, input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) exp_b[i] = 8'($urandom);
        cap_n = 0; cap_bits = 0; cap_sh = 0; sck_cs_high = 0;
        push_cmd(5'h01, 1);
        push_cmd(tx_code(w), n);
        push_cmd(5'h00, 1);
        for (int i = 0; i < n; i++) begin
            while (tx_full) @(negedge clk);
            tx_wr = 1'b1; tx_wdata = exp_b[i];
            @(negedge clk);
            tx_wr = 1'b0;
        end
        wait_frame_end();
        for (int i = 0; i < n && i < cap_n; i++) if (cap_b[i] !== exp_b[i]) bad++;
        check(cap_n == n, {req, " tx byte count"}, cap_n, n);
        check(bad == 0, {req, " tx byte values"}, bad, 0);
        check(sck_cs_high == 0, "R3/R4 clocks only inside chip select", sck_cs_high, 0);
    endtask

    task automatic drain_rx(input int n, output int bad);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            int t = 0;
            while (rx_empty && t < 5000) begin @(negedge clk); t++; end
            if (rx_rdata !== pat_b[i]) bad++;
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
    endtask

    task automatic run_rx(input int w, input int n, input string req);
        int bad;
        for (int i = 0; i < n; i++) pat_b[i] = 8'($urandom);
        rx_w = w; g = 0; rx_active = 1;
        push_cmd(5'h01, 1);
        push_cmd(rx_code(w), n);
        push_cmd(5'h00, 1);
        drain_rx(n, bad);
        wait_frame_end();
        rx_active = 0;
        check(bad == 0, {req, " rx byte values"}, bad, 0);
        check(rx_empty == 1'b1, "R7 rx queue empty after drain", int'(rx_empty), 1);
    endtask

    initial begin
        int r0;
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && spi_doe == 4'h0,
              "R1 pins after reset", {spi_cs_n, spi_sck, spi_doe}, 6'b100000);
        check(cmd_empty && tx_empty && rx_empty && !cmd_full && !tx_full && !rx_full,
              "R1 queues empty", {cmd_empty, tx_empty, rx_empty}, 3'b111);

        // R2: staging alone does nothing
        cmd_wr = 1'b1; cmd_wdata = word(5'h01, 1);
        @(negedge clk); cmd_wr = 1'b0;
        repeat (6) @(negedge clk);
        check(cmd_empty && spi_cs_n, "R2 staged word not queued", {cmd_empty, spi_cs_n}, 2'b11);
        cmd_go = 1'b1; @(negedge clk); cmd_go = 1'b0;
        repeat (4) @(negedge clk);
        check(spi_cs_n == 1'b0, "R2 R4 push then chip select low", int'(spi_cs_n), 0);
        r0 = sck_rises;
        push_cmd(5'h00, 1);
        repeat (4) @(negedge clk);
        check(spi_cs_n == 1'b1 && sck_rises == r0, "R4 chip select high, no clocks",
              sck_rises - r0, 0);

        // R10: unknown code and zero count are consumed silently
        r0 = sck_rises;
        push_cmd(5'h05, 3);
        push_cmd(5'h08, 0);
        push_cmd(5'h0E, 0);
        repeat (8) @(negedge clk);
        check(sck_rises == r0 && spi_cs_n && cmd_empty, "R10 ignored operations",
              sck_rises - r0, 0);

        // R5 and R6: directed widths
        run_tx(1, 5, "R5 single");
        run_tx(2, 6, "R5 dual");
        run_tx(4, 7, "R5 quad");
        run_rx(1, 5, "R6 single");
        run_rx(2, 6, "R6 dual");
        run_rx(4, 7, "R6 quad");

        // R8: stall on empty transmit queue
        cap_n = 0; cap_bits = 0; cap_sh = 0;
        exp_b[0] = 8'hA5; exp_b[1] = 8'h3C;
        push_cmd(5'h01, 1);
        push_cmd(5'h08, 2);
        r0 = sck_rises;
        repeat (40) @(negedge clk);
        check(sck_rises == r0 && spi_sck == 1'b0, "R8 no clocks while tx queue empty",
              sck_rises - r0, 0);
        tx_wr = 1'b1; tx_wdata = 8'hA5; @(negedge clk);
        tx_wdata = 8'h3C; @(negedge clk); tx_wr = 1'b0;
        push_cmd(5'h00, 1);
        wait_frame_end();
        check(cap_n == 2 && cap_b[0] == 8'hA5 && cap_b[1] == 8'h3C,
              "R8 bytes after stall", int'(cap_b[0]), 8'hA5);

        // R9: stall on full receive queue, then drain while the engine refills
        for (int i = 0; i < 18; i++) pat_b[i] = 8'($urandom);
        rx_w = 1; g = 0; rx_active = 1;
        push_cmd(5'h01, 1);
        push_cmd(5'h0C, 18);
        push_cmd(5'h00, 1);
        begin
            int t = 0;
            while (!rx_full && t < 5000) begin @(negedge clk); t++; end
        end
        repeat (4) @(negedge clk);
        r0 = sck_rises;
        repeat (30) @(negedge clk);
        check(rx_full && sck_rises == r0, "R9 no clocks while rx queue full", sck_rises - r0, 0);
        begin
            int bad;
            drain_rx(18, bad);
            check(bad == 0, "R9 R7 no byte lost across full stall", bad, 0);
        end
        wait_frame_end();
        rx_active = 0;
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0; @(negedge clk);
        check(rx_empty && !rx_full, "R7 pop on empty queue ignored", int'(rx_empty), 1);

        // R11: count above 255
        run_tx(4, 300, "R11 quad 300");
        run_rx(2, 260, "R11 dual 260");

        // Random mix of widths and directions (R3 ordering within each frame)
        for (int it = 0; it < 6; it++) begin
            int w, n;
            w = 1 << ($urandom % 3);
            n = 1 + ($urandom % 40);
            if ($urandom % 2) run_tx(w, n, "R3 R5 random");
            else              run_rx(w, n, "R3 R6 random");
        end

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule